// File: doc/BRIEF.md
# Real-Time Clock Control Registers and Interrupt Logic

This block is the register side of a real-time clock. A host reaches it through two port addresses. A write to the index port selects one of 128 byte locations. The data port then reads or writes the selected location. The block holds four control and status registers, three alarm bytes and a general-purpose byte store. It also owns the interrupt flags and the single interrupt line.

The block does not count time. An external calendar counter supplies the current seconds, minutes and hours as binary numbers. The same counter pulses an update-start strobe and an update-end strobe once per second. A separate divider supplies a periodic tick. The block compares the alarm bytes with the current time at each update end. It records the periodic, alarm and update-ended events as flags and raises the interrupt line while an enabled event is pending. Software acknowledges by reading the status register, which clears all flags.

Top module: `rtc_regs`

## Requirements
- R1: A write with `port_sel`=0 stores `wdata[6:0]` as the register index; bit 7 is dropped. A read with `port_sel`=0 returns 0xFF.
- R2: After `rst_n` is released, the control registers read A (index 10) = 0x26, B (index 11) = 0x02, C (index 12) = 0x00 and D (index 13) = 0x80, and `irq` is low.
- R3: Writes to indexes 12 and 13 change nothing. A write to index 10 stores bits 6:0, and bit 7 (the update-in-progress bit) keeps its value.
- R4: A write to index 11 with bit 7 (hold) set stores bit 4 (update interrupt enable) as 0 and clears A bit 7.
- R5: `upd_start` sets A bit 7 when B bit 7 is clear and leaves it alone when B bit 7 is set. `upd_end` clears A bit 7.
- R6: `upd_end` sets C bit 4 (update flag). If B bit 4 is set, it also sets C bit 7 (summary flag).
- R7: `per_tick` with B bit 6 set ORs 0xC0 into C (C bit 6 is the periodic flag). With B bit 6 clear, the tick has no effect.
- R8: On `upd_end` with B bit 5 set, the alarm matches when each of the alarm bytes (index 1 seconds, 3 minutes, 5 hours) either has bits 7:6 = 11 (any value) or decodes equal to the current value. Decoding is BCD when B bit 2 is 0 and binary when it is 1. A match ORs 0xA0 into C (C bit 5 is the alarm flag).
- R9: A data-port read of index 12 returns C and clears it to 0x00 on the next edge. A flag raised in that same cycle survives the clear.
- R10: `irq` equals C bit 7 in the same cycle.
- R11: `soft_rst` clears B bits 6, 5 and 3 and clears C to 0x00. The other bits of B are kept.
- R12: Indexes 14 to 127 are plain read/write storage. The time indexes 0, 2, 4 and 6 to 9 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst | input | 1 | Synchronous system reset of enables and flags |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects on the data port) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the current state |
| upd_start | input | 1 | Calendar update begins |
| upd_end | input | 1 | Calendar update completed |
| per_tick | input | 1 | Periodic rate tick |
| cur_sec | input | 8 | Current seconds, binary |
| cur_min | input | 8 | Current minutes, binary |
| cur_hour | input | 8 | Current hours, binary |
| irq | output | 1 | Interrupt line, high while C bit 7 is set |

## Verification
The alarm comparator is driven from a vector table. The table covers exact BCD matches, a one-count seconds mismatch and a hours-only mismatch. It also covers a binary-mode match, and a BCD-looking byte read in binary mode, which tells the two decode paths apart. Further rows cover all-wildcard bytes, a 0xFF byte acting as a wildcard, and 0x80 acting as a value rather than a wildcard, which pins down the two-bit wildcard test. Directed sequences cover the following:
- hold-mode interplay with the update-in-progress bit;
- the read-to-clear race against a simultaneous periodic tick;
- partial clearing by the soft reset;
- index bit 7 masking into the byte store.

// File: rtl/rtc_regs.sv
module rtc_regs #(
  parameter int IDX_W  = 7,
  parameter int RAM_LO = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       port_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       upd_start,
  input  logic       upd_end,
  input  logic       per_tick,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  output logic       irq
);
  localparam int NREG = 1 << IDX_W;
  localparam int RAM_N = NREG - RAM_LO;
  localparam logic [IDX_W-1:0] IX_ASEC = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_AMIN = IDX_W'(3);
  localparam logic [IDX_W-1:0] IX_AHR  = IDX_W'(5);
  localparam logic [IDX_W-1:0] IX_A    = IDX_W'(10);
  localparam logic [IDX_W-1:0] IX_B    = IDX_W'(11);
  localparam logic [IDX_W-1:0] IX_C    = IDX_W'(12);
  localparam logic [IDX_W-1:0] IX_D    = IDX_W'(13);
  localparam logic [IDX_W-1:0] IX_RAM  = IDX_W'(RAM_LO);
  localparam logic [7:0] A_RST = 8'h26;
  localparam logic [7:0] B_RST = 8'h02;
  localparam logic [7:0] D_VAL = 8'h80;

  logic [IDX_W-1:0] idx;
  logic [7:0] alm_s, alm_m, alm_h;
  logic [7:0] reg_a, reg_b, reg_c;
  logic [7:0] a_nxt, b_nxt, c_nxt, c_set;
  logic [7:0] ram [RAM_N];

  wire ix_wr  = wr_en & ~port_sel;
  wire dat_wr = wr_en & port_sel;
  wire dat_rd = rd_en & port_sel;
  wire a_wr   = dat_wr && idx == IX_A;
  wire b_wr   = dat_wr && idx == IX_B;
  wire c_rd   = dat_rd && idx == IX_C;
  wire in_ram = idx >= IX_RAM;
  wire bin_md = reg_b[2];

  function automatic logic [7:0] decode(input logic [7:0] v, input logic bin);
    return bin ? v : 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  function automatic logic field_ok(input logic [7:0] alm, input logic [7:0] cur,
                                    input logic bin);
    return (alm[7:6] == 2'b11) || (decode(alm, bin) == cur);
  endfunction

  wire alarm_hit = field_ok(alm_s, cur_sec, bin_md) &
                   field_ok(alm_m, cur_min, bin_md) &
                   field_ok(alm_h, cur_hour, bin_md);

  always_comb begin
    a_nxt = reg_a;
    if (a_wr) a_nxt = {reg_a[7], wdata[6:0]};
    if (upd_start && !reg_b[7]) a_nxt[7] = 1'b1;
    if (upd_end) a_nxt[7] = 1'b0;
    if (b_wr && wdata[7]) a_nxt[7] = 1'b0;
  end

  always_comb begin
    b_nxt = reg_b;
    if (b_wr) b_nxt = wdata[7] ? (wdata & 8'hEF) : wdata;
    if (soft_rst) b_nxt = b_nxt & 8'h97;
  end

  always_comb begin
    c_set = 8'h00;
    if (per_tick && reg_b[6]) c_set = c_set | 8'hC0;
    if (upd_end) begin
      c_set = c_set | 8'h10;
      if (reg_b[4]) c_set = c_set | 8'h80;
      if (reg_b[5] && alarm_hit) c_set = c_set | 8'hA0;
    end
    c_nxt = (c_rd ? 8'h00 : reg_c) | c_set;
    if (soft_rst) c_nxt = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      alm_s <= 8'h00;
      alm_m <= 8'h00;
      alm_h <= 8'h00;
      reg_a <= A_RST;
      reg_b <= B_RST;
      reg_c <= 8'h00;
    end else begin
      if (ix_wr) idx <= wdata[IDX_W-1:0];
      if (dat_wr && idx == IX_ASEC) alm_s <= wdata;
      if (dat_wr && idx == IX_AMIN) alm_m <= wdata;
      if (dat_wr && idx == IX_AHR)  alm_h <= wdata;
      reg_a <= a_nxt;
      reg_b <= b_nxt;
      reg_c <= c_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (dat_wr && in_ram) ram[idx - IX_RAM] <= wdata;
  end

  always_comb begin
    rdata = 8'h00;
    if (!port_sel) rdata = 8'hFF;
    else if (in_ram) rdata = ram[idx - IX_RAM];
    else begin
      case (idx)
        IX_ASEC: rdata = alm_s;
        IX_AMIN: rdata = alm_m;
        IX_AHR:  rdata = alm_h;
        IX_A:    rdata = reg_a;
        IX_B:    rdata = reg_b;
        IX_C:    rdata = reg_c;
        IX_D:    rdata = D_VAL;
        default: rdata = 8'h00;
      endcase
    end
  end

  assign irq = reg_c[7];
endmodule

module rtc_regs_chk #(parameter int IDX_W = 7) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             port_sel,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       wdata,
  input logic             upd_start,
  input logic             upd_end,
  input logic             per_tick,
  input logic             irq,
  input logic [IDX_W-1:0] idx,
  input logic [7:0]       reg_a,
  input logic [7:0]       reg_b,
  input logic [7:0]       reg_c
);
  wire at_a = idx == IDX_W'(10);
  wire at_b = idx == IDX_W'(11);
  wire at_c = idx == IDX_W'(12);

  // R3
  uip_wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel && at_a && !upd_start && !upd_end) |=> reg_a[7] == $past(reg_a[7]));
  // R3
  c_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel && at_c && !rd_en && !upd_end && !per_tick && !soft_rst) |=> $stable(reg_c));
  // R4
  hold_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel && at_b && wdata[7]) |=> (!reg_b[4] && !reg_a[7]));
  // R6
  upd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_end && !soft_rst) |=> (reg_c[4] && !reg_a[7]));
  // R7
  per_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_tick && reg_b[6] && !soft_rst) |=> (reg_c[7:6] == 2'b11));
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && port_sel && at_c && !upd_end && !per_tick) |=> (reg_c == 8'h00 && !irq));
  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (reg_c[6:4] != 3'b000));
  // R11
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (reg_c == 8'h00 && reg_b[6] == 1'b0 && reg_b[5] == 1'b0 && reg_b[3] == 1'b0));
endmodule

bind rtc_regs rtc_regs_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .port_sel(port_sel),
  .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .upd_start(upd_start),
  .upd_end(upd_end), .per_tick(per_tick), .irq(irq), .idx(idx),
  .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c)
);

// File: tb/sim_rtc_regs.sv
`timescale 1ns/1ps
module sim_rtc_regs;
  logic clk = 0, rst_n = 0, soft_rst = 0, port_sel = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, cur_sec = 0, cur_min = 0, cur_hour = 0;
  logic upd_start = 0, upd_end = 0, per_tick = 0;
  logic [7:0] rdata;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_regs u0 (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .port_sel(port_sel),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .upd_start(upd_start), .upd_end(upd_end), .per_tick(per_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .irq(irq));

  // {alarm sec, alarm min, alarm hour, binary mode, cur sec, cur min, cur hour, match}
  localparam logic [49:0] VEC [9] = '{
    {8'h30, 8'h45, 8'h12, 1'b0, 8'd30, 8'd45, 8'd12, 1'b1},
    {8'h31, 8'h45, 8'h12, 1'b0, 8'd30, 8'd45, 8'd12, 1'b0},
    {8'd30, 8'd45, 8'd12, 1'b1, 8'd30, 8'd45, 8'd12, 1'b1},
    {8'h30, 8'd45, 8'd12, 1'b1, 8'd30, 8'd45, 8'd12, 1'b0},
    {8'hC0, 8'hC0, 8'hC0, 1'b0, 8'd7,  8'd8,  8'd9,  1'b1},
    {8'hFF, 8'h45, 8'h12, 1'b0, 8'd59, 8'd45, 8'd12, 1'b1},
    {8'h80, 8'h45, 8'h12, 1'b0, 8'd0,  8'd45, 8'd12, 1'b0},
    {8'h30, 8'h45, 8'h13, 1'b0, 8'd30, 8'd45, 8'd12, 1'b0},
    {8'd5,  8'hC5, 8'd23, 1'b1, 8'd5,  8'd59, 8'd23, 1'b1}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus(input logic sel, input logic wr, input logic rd,
                     input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    port_sel = sel; wr_en = wr; rd_en = rd; wdata = d;
    #1 q = rdata;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wreg(input logic [7:0] i, input logic [7:0] d);
    logic [7:0] q;
    bus(0, 1, 0, i, q);
    bus(1, 1, 0, d, q);
  endtask

  task automatic rreg(input logic [7:0] i, output logic [7:0] q);
    logic [7:0] t;
    bus(0, 1, 0, i, t);
    bus(1, 0, 1, 8'h00, q);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: upd_start = 1;
      1: upd_end = 1;
      2: per_tick = 1;
      default: soft_rst = 1;
    endcase
    @(posedge clk); #1;
    upd_start = 0; upd_end = 0; per_tick = 0; soft_rst = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R2 irq", {7'd0, irq}, 8'h00);
    rreg(10, q); check("R2 A", q, 8'h26);
    rreg(11, q); check("R2 B", q, 8'h02);
    rreg(12, q); check("R2 C", q, 8'h00);
    rreg(13, q); check("R2 D", q, 8'h80);

    foreach (VEC[k]) begin
      logic [49:0] v;
      v = VEC[k];
      wreg(1, v[49:42]); wreg(3, v[41:34]); wreg(5, v[33:26]);
      wreg(11, v[25] ? 8'h26 : 8'h22);
      cur_sec = v[24:17]; cur_min = v[16:9]; cur_hour = v[8:1];
      pulse(1);
      @(negedge clk);
      check($sformatf("R8 vec%0d irq", k), {7'd0, irq}, {7'd0, v[0]});
      rreg(12, q);
      check($sformatf("R8 vec%0d C", k), q, v[0] ? 8'hB0 : 8'h10);
    end
    wreg(11, 8'h02);

    bus(0, 0, 1, 8'h00, q); check("R1 even read", q, 8'hFF);
    wreg(8'h8E, 8'h5A);
    rreg(14, q); check("R1 R12 index bit7 dropped", q, 8'h5A);
    wreg(127, 8'hA5);
    rreg(127, q); check("R12 top byte", q, 8'hA5);
    rreg(14, q); check("R12 low byte kept", q, 8'h5A);
    wreg(0, 8'h77);
    rreg(0, q); check("R12 time index", q, 8'h00);
    rreg(1, q); check("R12 alarm reads back", q, 8'd5);

    wreg(12, 8'hFF);
    rreg(12, q); check("R3 C write ignored", q, 8'h00);
    wreg(13, 8'h00);
    rreg(13, q); check("R3 D write ignored", q, 8'h80);
    pulse(0);
    rreg(10, q); check("R5 start sets UIP", q, 8'hA6);
    wreg(10, 8'h25);
    rreg(10, q); check("R3 UIP kept on write", q, 8'hA5);
    pulse(1);
    rreg(10, q); check("R5 end clears UIP", q, 8'h25);
    rreg(12, q); check("R6 UF only", q, 8'h10);
    rreg(12, q); check("R9 cleared after read", q, 8'h00);

    wreg(11, 8'h12);
    pulse(1);
    @(negedge clk);
    check("R10 irq with UIE", {7'd0, irq}, 8'h01);
    rreg(12, q); check("R6 UF+IRQF", q, 8'h90);
    @(negedge clk);
    check("R9 irq dropped", {7'd0, irq}, 8'h00);

    pulse(0);
    wreg(11, 8'h92);
    rreg(11, q); check("R4 UIE forced off", q, 8'h82);
    rreg(10, q); check("R4 UIP cleared", q, 8'h25);
    pulse(0);
    rreg(10, q); check("R5 no UIP in hold", q, 8'h25);
    wreg(11, 8'h02);

    pulse(2);
    rreg(12, q); check("R7 tick without PIE", q, 8'h00);
    wreg(11, 8'h42);
    pulse(2);
    @(negedge clk);
    check("R10 irq on tick", {7'd0, irq}, 8'h01);
    bus(0, 1, 0, 8'd12, q);
    @(negedge clk);
    port_sel = 1; rd_en = 1; per_tick = 1;
    #1 q = rdata;
    @(posedge clk); #1;
    rd_en = 0; per_tick = 0;
    check("R7 periodic flags", q, 8'hC0);
    bus(1, 0, 1, 8'h00, q); check("R9 same-cycle flag kept", q, 8'hC0);
    bus(1, 0, 1, 8'h00, q); check("R9 then clear", q, 8'h00);

    wreg(11, 8'h7E);
    pulse(2);
    pulse(3);
    @(negedge clk);
    check("R11 irq low", {7'd0, irq}, 8'h00);
    rreg(11, q); check("R11 B masked", q, 8'h16);
    rreg(12, q); check("R11 C cleared", q, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule